// File: doc/BRIEF.md
# Nibble Bit-Manipulation Memory Unit

This unit carries out single-byte bit operations on a byte in memory. A command carries an 8-bit operation code, a 4-bit immediate and a byte address. The immediate is placed over either the low or the high half of the byte, and one bit of the operation code selects which half. The AND form fills the other half of its mask with ones, so that half is untouched. The OR and exclusive-OR forms fill the other half with zeros.

The modify forms fetch the byte, combine it with the mask and store it back, with one read and one write. They leave the flags alone. The test forms fetch the byte and AND it with the mask. They update the zero and negative flags from the result and never write memory.

Commands enter on a valid/ready handshake. `cmd_ready` is high only while the unit is idle, so a command waits on the port until the previous one has finished. The operation fields must stay stable while `cmd_valid` is high and `cmd_ready` is low. Memory traffic uses a request/acknowledge byte port. The unit holds its request until it sees the acknowledge. `done` marks the end of each command.

Top module: `nibble_bitop_unit`

## Requirements
- R1: Operation 0x80 stores `byte & {4'hF, imm}`. Operation 0x81 stores `byte & {imm, 4'hF}`.
- R2: Operation 0x90 stores `byte | {4'h0, imm}`. Operation 0x91 stores `byte | {imm, 4'h0}`.
- R3: Operation 0x98 stores `byte ^ {4'h0, imm}`. Operation 0x99 stores `byte ^ {imm, 4'h0}`.
- R4: Every modify operation makes exactly one read and then one write, both to the command address. It leaves `flag_n` and `flag_z` unchanged.
- R5: Operation 0x88 makes one read and no write. It sets `flag_z` to `(byte & {4'h0, imm}) == 0` and clears `flag_n`.
- R6: Operation 0x89 makes one read and no write. With `m = byte & {imm, 4'h0}`, it sets `flag_z` to `m == 0` and `flag_n` to `m[7]`.
- R7: Any other operation code raises `illegal` together with `done`. It makes no memory access and leaves the flags unchanged.
- R8: While `mem_req` is high and `mem_ack` is low, the request, write enable, address and write data all hold their values into the next cycle.
- R9: `done` is a one-cycle pulse for each accepted command. `cmd_ready` is high only while the unit is idle and no memory request is out.
- R10: After reset, `cmd_ready` is 1, while `mem_req`, `done`, `illegal`, `flag_n` and `flag_z` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit idle; the command is taken on this edge |
| cmd_op | input | 8 | Operation code |
| cmd_imm | input | NIB_W | Nibble immediate |
| cmd_addr | input | ADDR_W | Target byte address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 2*NIB_W | Write data |
| mem_rdata | input | 2*NIB_W | Read data, valid with `mem_ack` on a read |
| mem_ack | input | 1 | Completes the pending access |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| done | output | 1 | One-cycle end-of-command pulse |
| illegal | output | 1 | Pulses with `done` for an unknown operation code |

## Verification
The assertions assume that memory raises `mem_ack` only while a request is pending, and for a single cycle per access. They also assume that a presented command stays stable until it is accepted. The bench memory model follows these rules. It answers only a pending request, after a latency of 0 to 2 cycles, and drops its acknowledge after one cycle. The bench offers a new command only after the previous `done`, so commands never overlap.

// File: rtl/nbm_pkg.sv
package nbm_pkg;
  typedef enum logic [2:0] {K_AND, K_OR, K_XOR, K_TST, K_BAD} kind_e;
  typedef enum logic [2:0] {S_IDLE, S_RD, S_TST, S_WR, S_DONE} state_e;

  localparam int OP_W = 8;
  localparam logic [OP_W-1:0] OP_AND_LO = 8'h80;
  localparam logic [OP_W-1:0] OP_AND_HI = 8'h81;
  localparam logic [OP_W-1:0] OP_TST_LO = 8'h88;
  localparam logic [OP_W-1:0] OP_TST_HI = 8'h89;
  localparam logic [OP_W-1:0] OP_OR_LO  = 8'h90;
  localparam logic [OP_W-1:0] OP_OR_HI  = 8'h91;
  localparam logic [OP_W-1:0] OP_XOR_LO = 8'h98;
  localparam logic [OP_W-1:0] OP_XOR_HI = 8'h99;
endpackage

// File: rtl/nbm_decode.sv
module nbm_decode
  import nbm_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output kind_e           kind,
  output logic            hi
);
  always_comb begin
    hi = op[0];
    unique case (op)
      OP_AND_LO, OP_AND_HI: kind = K_AND;
      OP_OR_LO,  OP_OR_HI:  kind = K_OR;
      OP_XOR_LO, OP_XOR_HI: kind = K_XOR;
      OP_TST_LO, OP_TST_HI: kind = K_TST;
      default:              kind = K_BAD;
    endcase
  end
endmodule

// File: rtl/nbm_alu.sv
module nbm_alu
  import nbm_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic [2*NIB_W-1:0] data,
  input  logic [NIB_W-1:0]   imm,
  input  kind_e              kind,
  input  logic               hi,
  output logic [2*NIB_W-1:0] result,
  output logic               n,
  output logic               z
);
  localparam int BW = 2 * NIB_W;
  localparam logic [NIB_W-1:0] ZEROS = '0;
  localparam logic [NIB_W-1:0] ONES  = '1;

  logic [BW-1:0] set_mask;
  logic [BW-1:0] keep_mask;
  logic [BW-1:0] masked;

  always_comb begin
    set_mask  = hi ? {imm, ZEROS} : {ZEROS, imm};
    keep_mask = hi ? {imm, ONES}  : {ONES, imm};
    masked    = data & set_mask;
    n         = hi & masked[BW-1];
    z         = (masked == '0);
    unique case (kind)
      K_AND:   result = data & keep_mask;
      K_OR:    result = data | set_mask;
      K_XOR:   result = data ^ set_mask;
      default: result = data;
    endcase
  end
endmodule

// File: rtl/nbm_ctrl.sv
module nbm_ctrl
  import nbm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cmd_valid,
  input  kind_e  kind_in,
  input  kind_e  kind_q,
  input  logic   mem_ack,
  output state_e state,
  output logic   fire,
  output logic   cmd_ready,
  output logic   mem_req,
  output logic   mem_we,
  output logic   done
);
  state_e nxt;

  assign cmd_ready = (state == S_IDLE);
  assign fire      = cmd_valid & cmd_ready;
  assign mem_req   = (state == S_RD) || (state == S_WR);
  assign mem_we    = (state == S_WR);
  assign done      = (state == S_DONE);

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE: if (fire) nxt = (kind_in == K_BAD) ? S_DONE : S_RD;
      S_RD:   if (mem_ack) nxt = (kind_q == K_TST) ? S_TST : S_WR;
      S_TST:  nxt = S_DONE;
      S_WR:   if (mem_ack) nxt = S_DONE;
      S_DONE: nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
endmodule

// File: rtl/nibble_bitop_unit.sv
module nibble_bitop_unit
  import nbm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NIB_W  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [7:0]          cmd_op,
  input  logic [NIB_W-1:0]    cmd_imm,
  input  logic [ADDR_W-1:0]   cmd_addr,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [2*NIB_W-1:0]  mem_wdata,
  input  logic [2*NIB_W-1:0]  mem_rdata,
  input  logic                mem_ack,
  output logic                flag_n,
  output logic                flag_z,
  output logic                done,
  output logic                illegal
);
  localparam int BW = 2 * NIB_W;

  kind_e             kind_in, kind_q;
  logic              hi_in, hi_q;
  logic [NIB_W-1:0]  imm_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BW-1:0]     data_q;
  logic [BW-1:0]     alu_res;
  logic              alu_n, alu_z;
  logic              fire;
  state_e            state;

  nbm_decode u_dec (.op(cmd_op), .kind(kind_in), .hi(hi_in));

  nbm_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .kind_in(kind_in),
    .kind_q(kind_q), .mem_ack(mem_ack), .state(state), .fire(fire),
    .cmd_ready(cmd_ready), .mem_req(mem_req), .mem_we(mem_we), .done(done)
  );

  nbm_alu #(.NIB_W(NIB_W)) u_alu (
    .data(data_q), .imm(imm_q), .kind(kind_q), .hi(hi_q),
    .result(alu_res), .n(alu_n), .z(alu_z)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= K_BAD;
      hi_q   <= 1'b0;
      imm_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      flag_n <= 1'b0;
      flag_z <= 1'b0;
    end else begin
      if (fire) begin
        kind_q <= kind_in;
        hi_q   <= hi_in;
        imm_q  <= cmd_imm;
        addr_q <= cmd_addr;
      end
      if (state == S_RD && mem_ack) data_q <= mem_rdata;
      if (state == S_TST) begin
        flag_n <= alu_n;
        flag_z <= alu_z;
      end
    end
  end

  assign mem_addr  = addr_q;
  assign mem_wdata = alu_res;
  assign illegal   = done && (kind_q == K_BAD);
endmodule

// File: rtl/nbm_checker.sv
module nbm_checker #(
  parameter int ADDR_W = 16,
  parameter int NIB_W  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic               mem_req,
  input logic               mem_we,
  input logic [ADDR_W-1:0]  mem_addr,
  input logic [2*NIB_W-1:0] mem_wdata,
  input logic               mem_ack,
  input logic               flag_n,
  input logic               flag_z,
  input logic               done,
  input logic               illegal
);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mem_req);

  assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  assert_illegal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (done && !mem_req));

  assert_flags_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |=> ($stable(flag_n) && $stable(flag_z)));
endmodule

bind nibble_bitop_unit nbm_checker #(.ADDR_W(ADDR_W), .NIB_W(NIB_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ack(mem_ack), .flag_n(flag_n), .flag_z(flag_z), .done(done), .illegal(illegal)
);

// File: tb/nibble_bitop_unit_tb_top.sv
`timescale 1ns/1ps
module nibble_bitop_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [7:0]  cmd_op = '0;
  logic [3:0]  cmd_imm = '0;
  logic [15:0] cmd_addr = '0;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic        flag_n, flag_z, done, illegal;

  always #2.5 clk = ~clk;

  nibble_bitop_unit dut_i (.*);

  logic [7:0] mem [16];
  int lat = 0;
  int n_rd = 0, n_wr = 0;
  logic [15:0] last_addr;
  int vectors = 0, errors = 0;
  logic exp_n = 1'b0, exp_z = 1'b0;

  initial begin : responder
    int wait_cnt;
    wait_cnt = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (wait_cnt >= lat) begin
          mem_ack = 1'b1;
          last_addr = mem_addr;
          if (mem_we) begin mem[mem_addr[3:0]] = mem_wdata; n_wr++; end
          else begin mem_rdata = mem[mem_addr[3:0]]; n_rd++; end
          wait_cnt = 0;
        end else wait_cnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  task automatic run(input logic [7:0] op, input logic [3:0] imm,
                     input logic [15:0] addr, input logic [7:0] b);
    logic [7:0] e;
    logic [7:0] m;
    bit modify, test, bad;
    int cyc;
    mem[addr[3:0]] = b;
    n_rd = 0; n_wr = 0;
    modify = 1'b0; test = 1'b0; bad = 1'b0; e = b;
    case (op)
      8'h80: begin e = b & {4'hF, imm}; modify = 1'b1; end
      8'h81: begin e = b & {imm, 4'hF}; modify = 1'b1; end
      8'h90: begin e = b | {4'h0, imm}; modify = 1'b1; end
      8'h91: begin e = b | {imm, 4'h0}; modify = 1'b1; end
      8'h98: begin e = b ^ {4'h0, imm}; modify = 1'b1; end
      8'h99: begin e = b ^ {imm, 4'h0}; modify = 1'b1; end
      8'h88: begin m = b & {4'h0, imm}; exp_n = 1'b0; exp_z = (m == 0); test = 1'b1; end
      8'h89: begin m = b & {imm, 4'h0}; exp_n = m[7]; exp_z = (m == 0); test = 1'b1; end
      default: bad = 1'b1;
    endcase
    @(negedge clk);
    chk(cmd_ready, "R9 ready when idle", cmd_ready, 1);
    cmd_op = op; cmd_imm = imm; cmd_addr = addr; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    cyc = 0;
    while (!done && cyc < 50) begin @(negedge clk); cyc++; end
    vectors++;
    chk(done, "R9 done timeout", done, 1);
    chk(illegal == bad, "R7 illegal", illegal, bad);
    chk(mem[addr[3:0]] == e,
        modify ? (op[4] ? (op[3] ? "R3 xor result" : "R2 or result") : "R1 and result")
               : "R5/R6 byte untouched", mem[addr[3:0]], e);
    chk(n_rd == (bad ? 0 : 1), bad ? "R7 no read" : "R4 one read", n_rd, bad ? 0 : 1);
    chk(n_wr == (modify ? 1 : 0), modify ? "R4 one write" : "R5 R6 no write", n_wr, modify ? 1 : 0);
    if (!bad) chk(last_addr == addr, "R4 address", last_addr, addr);
    chk(flag_n == exp_n, test ? (op[0] ? "R6 N" : "R5 N") : "R4 R7 N kept", flag_n, exp_n);
    chk(flag_z == exp_z, test ? (op[0] ? "R6 Z" : "R5 Z") : "R4 R7 Z kept", flag_z, exp_z);
    @(negedge clk);
    chk(!done, "R9 done one cycle", done, 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    report();
  end

  initial begin : main
    logic [7:0] ops [8];
    logic [7:0] bad_ops [6];
    ops = '{8'h80, 8'h81, 8'h90, 8'h91, 8'h98, 8'h99, 8'h88, 8'h89};
    bad_ops = '{8'h00, 8'h82, 8'h8A, 8'h97, 8'h9A, 8'hFF};
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    vectors++;
    chk(cmd_ready == 1'b1, "R10 ready", cmd_ready, 1);
    chk(mem_req == 1'b0, "R10 req", mem_req, 0);
    chk(done == 1'b0 && illegal == 1'b0, "R10 done/illegal", {done, illegal}, 0);
    chk(flag_n == 1'b0 && flag_z == 1'b0, "R10 flags", {flag_n, flag_z}, 0);
    for (int o = 0; o < 8; o++)
      for (int imm = 0; imm < 16; imm++)
        for (int k = 0; k < 34; k++) begin
          logic [7:0] b;
          b = (k < 32) ? 8'((k * 37 + 5) & 255) : ((k == 32) ? 8'h00 : 8'hFF);
          lat = (k + imm) % 3;
          run(ops[o], 4'(imm), 16'((k * 16'h1235) ^ imm), b);
        end
    for (int o = 0; o < 6; o++)
      for (int imm = 0; imm < 16; imm++) begin
        lat = imm % 3;
        run(bad_ops[o], 4'(imm), 16'(imm * 16'h0101), 8'(imm * 17));
      end
    report();
  end
endmodule